// File: doc/BRIEF.md
# Prioritised memory space select decoder

This block sits between a microcontroller bus and three on-chip memory regions: a SRAM/I/O region, a secondary (boot) flash and a main flash. The microcontroller keeps program and data in separate spaces. A code strobe marks an instruction fetch and a data strobe marks a data read. Address decoding happens elsewhere and delivers one range-hit flag per region. In every cycle the block turns those flags and the strobes into at most one chip select.

Two rules decide which region answers. First, each region is gated by a per-space enable held in an 8-bit mapping register. A region that is not enabled for the active space counts as not hit. Second, the hits that survive the gating are resolved by fixed priority. The SRAM/I/O region wins over the secondary flash, and the secondary flash wins over the main flash.

The mapping register loads a build-time boot value at reset. Software may rewrite it at any time through a small register write port. This lets firmware move the two flash regions between spaces, for example to exchange them after boot.

Top module: `mem_space_sel`

## Requirements
- R1: When several gated hits are present, the select follows the priority SRAM/I/O (`cs_sram`), then secondary flash (`cs_boot`), then main flash (`cs_main`).
- R2: During a code access (`code_stb`=1, `data_stb`=0), map bit 0 enables SRAM/I/O, bit 1 enables the secondary flash and bit 2 enables the main flash. A value of 1 means reachable.
- R3: During a data access (`data_stb`=1, `code_stb`=0), map bit 3 enables the secondary flash and bit 4 enables the main flash. SRAM/I/O is always reachable for data.
- R4: A region that is hit but disabled for the active space is skipped, and the select passes to the next lower-priority region that is enabled and hit.
- R5: At most one select is high at any time. No select is high while no strobe is active, or while no enabled region is hit.
- R6: When both strobes are high in the same cycle, every select stays low and `strobe_err` is 1. Otherwise `strobe_err` is 0.
- R7: After reset, `cfg_rdata` reads `BOOT_MAP` (default 8'h8D: bits 7, 3, 2 and 0 set).
- R8: A clock edge with `cfg_sel`=1 and `cfg_we`=1 stores `cfg_wdata` into bits 7 and 4..0. Bits 6 and 5 always read back as 0.
- R9: A clock edge with `cfg_sel`=0 or `cfg_we`=0 leaves the mapping register unchanged.
- R10: An access in the same cycle as a write still uses the old mapping. Accesses from the cycle after the write edge use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_stb | input | 1 | Program fetch strobe, active high |
| data_stb | input | 1 | Data read strobe, active high |
| hit_sram | input | 1 | Address falls in the SRAM/I/O range |
| hit_boot | input | 1 | Address falls in the secondary flash range |
| hit_main | input | 1 | Address falls in the main flash range |
| cfg_sel | input | 1 | Register-space address hit for the mapping register |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Mapping register read-back |
| cs_sram | output | 1 | SRAM/I/O select |
| cs_boot | output | 1 | Secondary flash select |
| cs_main | output | 1 | Main flash select |
| strobe_err | output | 1 | Both strobes active in one cycle |

## Verification
A corrupted mapping bit shows up in one of two ways. The wrong region is selected on the very next access that hits it in the affected space, or no region is selected at all. The same fault is also visible at once on `cfg_rdata`, which reflects the register in the cycle after the write edge. Faults in the priority chain or the strobe classification are combinational, so they show on the selects in the same cycle as the stimulus. The tests therefore pair each mapping value with accesses in both spaces and with overlapping hit patterns.

// File: rtl/mss_pkg.sv
package mss_pkg;
   localparam int unsigned MAP_BITS = 8;
   localparam int unsigned NUM_REG  = 3;
   // region index = priority rank, 0 is highest
   localparam int unsigned IDX_SRAM = 0;
   localparam int unsigned IDX_BOOT = 1;
   localparam int unsigned IDX_MAIN = 2;
   // field positions inside the mapping register
   localparam int unsigned B_CODE_SRAM = 0;
   localparam int unsigned B_CODE_BOOT = 1;
   localparam int unsigned B_CODE_MAIN = 2;
   localparam int unsigned B_DATA_BOOT = 3;
   localparam int unsigned B_DATA_MAIN = 4;
   localparam int unsigned B_IO_MODE   = 7;
   localparam logic [MAP_BITS-1:0] WR_MASK = 8'h9F;

   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_CODE = 2'd1,
      ACC_DATA = 2'd2,
      ACC_BAD  = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/mss_map_reg.sv
module mss_map_reg #(
   parameter int unsigned          W         = 8,
   parameter logic [W-1:0]         RST_VAL   = '0,
   parameter logic [W-1:0]         KEEP_MASK = '1,
   parameter bit                   ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (wr_en) nxt = wr_data & KEEP_MASK;
   end

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL & KEEP_MASK;
            else        q <= nxt;
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) q <= RST_VAL & KEEP_MASK;
            else        q <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/mss_space_gate.sv
module mss_space_gate
   import mss_pkg::*;
#(
   parameter int unsigned N = 3
) (
   input  logic         code_stb,
   input  logic         data_stb,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] code_en,
   input  logic [N-1:0] data_en,
   output logic [N-1:0] req,
   output logic         err
);
   acc_kind_e kind;

   always_comb begin
      unique case ({data_stb, code_stb})
         2'b01:   kind = ACC_CODE;
         2'b10:   kind = ACC_DATA;
         2'b11:   kind = ACC_BAD;
         default: kind = ACC_IDLE;
      endcase
   end

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_gate
         always_comb begin
            unique case (kind)
               ACC_CODE: req[i] = hit[i] & code_en[i];
               ACC_DATA: req[i] = hit[i] & data_en[i];
               default:  req[i] = 1'b0;
            endcase
         end
      end
   endgenerate

   assign err = (kind == ACC_BAD);
endmodule

// File: rtl/mss_prio_sel.sv
module mss_prio_sel #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [N:0] taken;

   assign taken[0] = 1'b0;

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_rank
         assign gnt[i]     = req[i] & ~taken[i];
         assign taken[i+1] = taken[i] | req[i];
      end
   endgenerate
endmodule

// File: rtl/mem_space_sel.sv
module mem_space_sel
   import mss_pkg::*;
#(
   parameter int unsigned   MAP_W     = 8,
   parameter logic [MAP_W-1:0] BOOT_MAP = 8'h8D,
   parameter bit            ASYNC_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             code_stb,
   input  logic             data_stb,
   input  logic             hit_sram,
   input  logic             hit_boot,
   input  logic             hit_main,
   input  logic             cfg_sel,
   input  logic             cfg_we,
   input  logic [MAP_W-1:0] cfg_wdata,
   output logic [MAP_W-1:0] cfg_rdata,
   output logic             cs_sram,
   output logic             cs_boot,
   output logic             cs_main,
   output logic             strobe_err
);
   localparam int unsigned N = NUM_REG;

   generate
      if (MAP_W != MAP_BITS) begin : g_bad_width
         $error("mem_space_sel: MAP_W must equal 8");
      end
      if ((BOOT_MAP & ~WR_MASK) != '0) begin : g_bad_boot
         $error("mem_space_sel: BOOT_MAP sets unused bits");
      end
   endgenerate

   logic [MAP_W-1:0] map_q;
   logic [N-1:0]     hit_v, code_en, data_en, req, gnt;

   mss_map_reg #(
      .W(MAP_W), .RST_VAL(BOOT_MAP), .KEEP_MASK(WR_MASK), .ASYNC_RST(ASYNC_RST)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_sel & cfg_we),
      .wr_data(cfg_wdata), .q(map_q)
   );

   assign hit_v[IDX_SRAM]   = hit_sram;
   assign hit_v[IDX_BOOT]   = hit_boot;
   assign hit_v[IDX_MAIN]   = hit_main;
   assign code_en[IDX_SRAM] = map_q[B_CODE_SRAM];
   assign code_en[IDX_BOOT] = map_q[B_CODE_BOOT];
   assign code_en[IDX_MAIN] = map_q[B_CODE_MAIN];
   assign data_en[IDX_SRAM] = 1'b1;
   assign data_en[IDX_BOOT] = map_q[B_DATA_BOOT];
   assign data_en[IDX_MAIN] = map_q[B_DATA_MAIN];

   mss_space_gate #(.N(N)) u_gate (
      .code_stb(code_stb), .data_stb(data_stb), .hit(hit_v),
      .code_en(code_en), .data_en(data_en), .req(req), .err(strobe_err)
   );

   mss_prio_sel #(.N(N)) u_prio (.req(req), .gnt(gnt));

   assign cs_sram   = gnt[IDX_SRAM];
   assign cs_boot   = gnt[IDX_BOOT];
   assign cs_main   = gnt[IDX_MAIN];
   assign cfg_rdata = map_q;
endmodule

// File: rtl/mem_space_sel_chk.sv
module mem_space_sel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       code_stb,
   input logic       data_stb,
   input logic       hit_sram,
   input logic       cfg_sel,
   input logic       cfg_we,
   input logic [7:0] cfg_wdata,
   input logic [7:0] cfg_rdata,
   input logic       cs_sram,
   input logic       cs_boot,
   input logic       cs_main,
   input logic       strobe_err
);
   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_main, cs_boot, cs_sram}));

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!code_stb && !data_stb) |-> !(cs_sram || cs_boot || cs_main));

   p_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (code_stb && data_stb) |-> (strobe_err && !(cs_sram || cs_boot || cs_main)));

   p_no_false_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(code_stb && data_stb) |-> !strobe_err);

   p_sram_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_stb && !code_stb && hit_sram) |-> cs_sram);

   p_sram_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (code_stb && !data_stb && hit_sram && cfg_rdata[0]) |-> cs_sram);

   p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[6:5] == 2'b00);

   p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel && cfg_we) |=> (cfg_rdata == ($past(cfg_wdata) & 8'h9F)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_sel && cfg_we) |=> $stable(cfg_rdata));
endmodule

bind mem_space_sel mem_space_sel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .code_stb(code_stb), .data_stb(data_stb),
   .hit_sram(hit_sram), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
   .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cs_sram(cs_sram),
   .cs_boot(cs_boot), .cs_main(cs_main), .strobe_err(strobe_err)
);

// File: tb/mem_space_sel_test.sv
`timescale 1ns/1ps
module mem_space_sel_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       code_stb = 0, data_stb = 0;
   logic       hit_sram = 0, hit_boot = 0, hit_main = 0;
   logic       cfg_sel = 0, cfg_we = 0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       cs_sram, cs_boot, cs_main, strobe_err;
   int         checks = 0, fails = 0;
   bit         done = 0;

   always #4 clk = ~clk;

   mem_space_sel uut (
      .clk(clk), .rst_n(rst_n), .code_stb(code_stb), .data_stb(data_stb),
      .hit_sram(hit_sram), .hit_boot(hit_boot), .hit_main(hit_main),
      .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cs_sram(cs_sram), .cs_boot(cs_boot),
      .cs_main(cs_main), .strobe_err(strobe_err)
   );

   // selects as {main, boot, sram}, plus error
   task automatic chk_sel(input string req, input logic [2:0] exp_cs, input logic exp_err);
      logic [2:0] got;
      got = {cs_main, cs_boot, cs_sram};
      checks++;
      if (got !== exp_cs || strobe_err !== exp_err) begin
         fails++;
         $display("FAIL %s: cs=%b err=%b expected cs=%b err=%b", req, got, strobe_err, exp_cs, exp_err);
      end
   endtask

   task automatic chk_map(input string req, input logic [7:0] exp);
      checks++;
      if (cfg_rdata !== exp) begin
         fails++;
         $display("FAIL %s: map=%h expected %h", req, cfg_rdata, exp);
      end
   endtask

   // drive an access at the falling edge and check it mid-cycle
   task automatic access(input string req, input logic c, input logic d,
                         input logic [2:0] hits, input logic [2:0] exp_cs, input logic exp_err);
      @(negedge clk);
      code_stb = c; data_stb = d;
      {hit_main, hit_boot, hit_sram} = hits;
      #1 chk_sel(req, exp_cs, exp_err);
      @(negedge clk);
      code_stb = 0; data_stb = 0; {hit_main, hit_boot, hit_sram} = 3'b000;
   endtask

   task automatic write_map(input logic s, input logic w, input logic [7:0] v);
      @(negedge clk);
      cfg_sel = s; cfg_we = w; cfg_wdata = v;
      @(negedge clk);
      cfg_sel = 0; cfg_we = 0; cfg_wdata = 8'h00;
   endtask

   task automatic t_reset();
      chk_map("R7 boot value", 8'h8D);
      chk_sel("R5 reset idle", 3'b000, 1'b0);
   endtask

   task automatic t_boot_map();
      access("R5 hits without strobe", 0, 0, 3'b111, 3'b000, 0);
      access("R1 code all hits", 1, 0, 3'b111, 3'b001, 0);
      access("R4 code boot disabled falls to main", 1, 0, 3'b110, 3'b100, 0);
      access("R2 code boot only disabled", 1, 0, 3'b010, 3'b000, 0);
      access("R3 data all hits sram", 0, 1, 3'b111, 3'b001, 0);
      access("R1 data boot over main", 0, 1, 3'b110, 3'b010, 0);
      access("R3 data main disabled", 0, 1, 3'b100, 3'b000, 0);
      access("R6 both strobes", 1, 1, 3'b111, 3'b000, 1);
   endtask

   task automatic t_writes();
      write_map(1, 1, 8'hFF);
      chk_map("R8 unused bits read 0", 8'h9F);
      write_map(0, 1, 8'h00);
      chk_map("R9 no write without sel", 8'h9F);
      write_map(1, 0, 8'h00);
      chk_map("R9 no write without we", 8'h9F);
      write_map(1, 1, 8'h02);
      chk_map("R8 write 02", 8'h02);
      access("R4 code sram disabled to boot", 1, 0, 3'b011, 3'b010, 0);
      access("R2 code main disabled", 1, 0, 3'b100, 3'b000, 0);
      access("R3 data flash disabled", 0, 1, 3'b110, 3'b000, 0);
      access("R3 data sram always", 0, 1, 3'b001, 3'b001, 0);
   endtask

   task automatic t_swap();
      write_map(1, 1, 8'h0C);
      access("R2 code main only", 1, 0, 3'b110, 3'b100, 0);
      access("R3 data boot", 0, 1, 3'b110, 3'b010, 0);
      // write and access in the same cycle: old mapping then new
      @(negedge clk);
      cfg_sel = 1; cfg_we = 1; cfg_wdata = 8'h12;
      code_stb = 1; {hit_main, hit_boot, hit_sram} = 3'b110;
      #1 chk_sel("R10 same cycle uses old map", 3'b100, 0);
      @(negedge clk);
      cfg_sel = 0; cfg_we = 0;
      #1 chk_sel("R10 next cycle uses new map", 3'b010, 0);
      @(negedge clk);
      code_stb = 0; {hit_main, hit_boot, hit_sram} = 3'b000;
      access("R10 data swapped to main", 0, 1, 3'b110, 3'b100, 0);
      chk_map("R10 swapped map", 8'h12);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 t_reset();
      rst_n = 1;
      t_boot_map();
      t_writes();
      t_swap();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule